// File: doc/BRIEF.md
# Host Command Gating Controller

This block sits on the host side of a link to a peripheral that runs its own initialization routine after power-up. It decides when the host may start sending commands to that peripheral. The peripheral drives an asynchronous status line that is high while initialization is running and low once it has finished. The block brings this line into the host clock domain, filters it, and runs a local timeout counter that starts when the host-side reset is released.

There are two classes of command, and each has its own permission rule. Ordinary commands may be sent at the first of two events: the peripheral reports done, or the local timeout runs out. Compound commands may be sent only after the peripheral reports done. The timeout never permits them, and there is no upper limit on how long they wait, because the peripheral can need several seconds. Each class has a request input. A request is stalled while its permission is false and is accepted on the first cycle its permission is true. The block then passes a one-cycle fire pulse to the bus engine downstream.

Top module: `hcg_cmd_gate`

## Requirements
- R1: While reset is asserted and right after it, both permission outputs, both ready outputs and both fire outputs are low.
- R2: The status input passes through two synchronizer flops. If it is held low from the drive point before clock edge k, the compound permission is first seen high after edge k+3, which is four rising edges.
- R3: Done is recognised only after two consecutive low synchronized samples. A low pulse on the status line that is caught by only one sampling edge grants nothing.
- R4: With the status line held high, ordinary permission is low after LIMIT-1 rising edges following reset release and high after LIMIT edges. LIMIT = CLK_HZ/1_000_000 × TIMEOUT_US.
- R5: The timeout never grants compound permission. Compound permission stays low for as long as the status line stays high.
- R6: Ordinary permission is granted by done alone, together with compound permission, before the timeout has run out.
- R7: Once a permission is high it stays high until reset, even if the status line goes high again.
- R8: A request of either class whose permission is low sees its ready output low and produces no fire pulse.
- R9: Each ready output equals its class permission, and a fire output is high in exactly the cycles where its request and ready are both high.
- R10: Asserting reset in the middle of operation clears both permissions, and the timeout count starts again from zero at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset; the timeout starts at its release |
| init_busy_i | input | 1 | Peripheral status, asynchronous; high = initializing, low = done |
| ord_req_i | input | 1 | Ordinary command request, held until accepted |
| cmp_req_i | input | 1 | Compound command request, held until accepted |
| ord_perm_o | output | 1 | Ordinary commands permitted (sticky) |
| cmp_perm_o | output | 1 | Compound commands permitted (sticky) |
| ord_rdy_o | output | 1 | Ready for the ordinary request |
| cmp_rdy_o | output | 1 | Ready for the compound request |
| ord_fire_o | output | 1 | Ordinary request accepted this cycle |
| cmp_fire_o | output | 1 | Compound request accepted this cycle |

## Verification
The assertions assume that a requester keeps its request asserted until it sees the fire pulse. They also assume that the status line settles long enough for the synchronizer to capture it, so any level change is seen by at least one sampling edge. The stimulus changes every input only at the falling clock edge and holds each request high across the stall cycles. It produces the only deliberate glitch, a status low pulse exactly one sampling edge wide, to show that the two-sample filter rejects it. Timeout checks use a one-microsecond limit (125 cycles), so the terminal count and the cycles around it are reached within the run.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
  localparam int unsigned NUM_CLASS = 2;
  localparam int unsigned CLS_ORD = 0;
  localparam int unsigned CLS_CMP = 1;

  // Number of clock cycles in a window of the given length in microseconds.
  function automatic longint unsigned timeout_cycles(input longint unsigned clk_hz,
                                                     input longint unsigned win_us);
    return (clk_hz / 64'd1_000_000) * win_us;
  endfunction

  // Counter width able to hold values 0..limit.
  function automatic int unsigned count_width(input longint unsigned limit);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= limit) w++;
    return w;
  endfunction
endpackage

// File: rtl/hcg_status_filter.sv
module hcg_status_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOW_RUN     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async_i,
  output logic sync_low_o,
  output logic done_o
);
  localparam int unsigned RW = hcg_pkg::count_width(LOW_RUN);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [RW-1:0]          run_q;
  logic                   done_q;
  logic                   s_low;

  // Synchronizer chain; resets to "busy" so nothing is read as done.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], busy_async_i};
  end

  assign s_low = ~chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!s_low)                     run_q <= '0;
      else if (run_q != RW'(LOW_RUN)) run_q <= run_q + 1'b1;
      if (s_low && (run_q == RW'(LOW_RUN - 1))) done_q <= 1'b1;
    end
  end

  assign sync_low_o = s_low;
  assign done_o     = done_q;
endmodule

// File: rtl/hcg_timeout.sv
module hcg_timeout #(
  parameter longint unsigned LIMIT = 64'd12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired_o
);
  localparam int unsigned CW = hcg_pkg::count_width(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == CW'(LIMIT - 1)) exp_q <= 1'b1;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/hcg_class_gate.sv
module hcg_class_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  input  logic req_i,
  output logic perm_o,
  output logic rdy_o,
  output logic fire_o
);
  logic held_q;

  // Remember any past grant; the live grant takes effect without delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (grant_i) held_q <= 1'b1;
  end

  assign perm_o = held_q | grant_i;
  assign rdy_o  = perm_o;
  assign fire_o = req_i & rdy_o;
endmodule

// File: rtl/hcg_cmd_gate.sv
module hcg_cmd_gate #(
  parameter longint unsigned CLK_HZ     = 64'd125_000_000,
  parameter longint unsigned TIMEOUT_US = 64'd100_000,
  parameter int unsigned     LOW_RUN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_busy_i,
  input  logic ord_req_i,
  input  logic cmp_req_i,
  output logic ord_perm_o,
  output logic cmp_perm_o,
  output logic ord_rdy_o,
  output logic cmp_rdy_o,
  output logic ord_fire_o,
  output logic cmp_fire_o
);
  import hcg_pkg::*;

  localparam longint unsigned LIMIT = timeout_cycles(CLK_HZ, TIMEOUT_US);

  // Named internal events, visible to the bound checker.
  logic sync_low_w;
  logic done_w;
  logic tmo_w;
  logic [NUM_CLASS-1:0] grant_w, req_w, perm_w, rdy_w, fire_w;

  hcg_status_filter #(.SYNC_STAGES(2), .LOW_RUN(LOW_RUN)) u_filt (
    .clk(clk), .rst_n(rst_n), .busy_async_i(init_busy_i),
    .sync_low_o(sync_low_w), .done_o(done_w)
  );

  hcg_timeout #(.LIMIT(LIMIT)) u_tmo (
    .clk(clk), .rst_n(rst_n), .expired_o(tmo_w)
  );

  // Ordinary: first of done or timeout. Compound: done only.
  assign grant_w[CLS_ORD] = done_w | tmo_w;
  assign grant_w[CLS_CMP] = done_w;
  assign req_w[CLS_ORD]   = ord_req_i;
  assign req_w[CLS_CMP]   = cmp_req_i;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    hcg_class_gate u_gate (
      .clk(clk), .rst_n(rst_n), .grant_i(grant_w[c]), .req_i(req_w[c]),
      .perm_o(perm_w[c]), .rdy_o(rdy_w[c]), .fire_o(fire_w[c])
    );
  end

  assign ord_perm_o = perm_w[CLS_ORD];
  assign cmp_perm_o = perm_w[CLS_CMP];
  assign ord_rdy_o  = rdy_w[CLS_ORD];
  assign cmp_rdy_o  = rdy_w[CLS_CMP];
  assign ord_fire_o = fire_w[CLS_ORD];
  assign cmp_fire_o = fire_w[CLS_CMP];
endmodule

// File: rtl/hcg_cmd_gate_chk.sv
module hcg_cmd_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_low,
  input logic ord_req,
  input logic cmp_req,
  input logic ord_perm,
  input logic cmp_perm,
  input logic ord_rdy,
  input logic cmp_rdy,
  input logic ord_fire,
  input logic cmp_fire
);
  // R7: permissions never drop while out of reset.
  assert_ord_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ord_perm |=> ord_perm);
  assert_cmp_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_perm |=> cmp_perm);

  // R3: compound grant only after two consecutive low synchronized samples.
  assert_two_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_perm) |-> ($past(sync_low) && $past(sync_low, 2)));

  // R5/R6: compound permission implies ordinary permission.
  assert_cmp_implies_ord_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_perm |-> ord_perm);

  // R8: stalled requests do not fire.
  assert_ord_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_req && !ord_perm) |-> (!ord_fire && !ord_rdy));
  assert_cmp_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !cmp_perm) |-> (!cmp_fire && !cmp_rdy));

  // R9: a fire pulse needs both request and ready.
  assert_ord_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ord_fire |-> (ord_req && ord_rdy));
  assert_cmp_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |-> (cmp_req && cmp_rdy));
endmodule

bind hcg_cmd_gate hcg_cmd_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_low(sync_low_w),
  .ord_req(ord_req_i), .cmp_req(cmp_req_i),
  .ord_perm(ord_perm_o), .cmp_perm(cmp_perm_o),
  .ord_rdy(ord_rdy_o), .cmp_rdy(cmp_rdy_o),
  .ord_fire(ord_fire_o), .cmp_fire(cmp_fire_o)
);

// File: tb/hcg_cmd_gate_tb.sv
module hcg_cmd_gate_tb_top;
  localparam longint unsigned CLK_HZ = 64'd125_000_000;
  localparam longint unsigned WIN_US = 64'd1;
  localparam int LIM = int'((CLK_HZ / 1_000_000) * WIN_US); // 125 edges

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b1, oreq = 1'b0, creq = 1'b0;
  logic operm, cperm, ordy, crdy, ofire, cfire;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  hcg_cmd_gate #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(WIN_US), .LOW_RUN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_busy_i(busy),
    .ord_req_i(oreq), .cmp_req_i(creq),
    .ord_perm_o(operm), .cmp_perm_o(cperm),
    .ord_rdy_o(ordy), .cmp_rdy_o(crdy),
    .ord_fire_o(ofire), .cmp_fire_o(cfire)
  );

  // {busy, ord_req, cmp_req, exp_ord_perm, exp_cmp_perm}
  localparam int NV = 11;
  localparam logic [4:0] VEC [NV] = '{
    5'b1_00_00, 5'b0_11_00, 5'b1_11_00, 5'b1_11_00, 5'b1_00_00,
    5'b0_11_00, 5'b0_11_00, 5'b0_11_00, 5'b0_11_11, 5'b1_10_11,
    5'b1_01_11 };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at falling edge, pass one rising edge, sample at the next falling edge.
  task automatic step(input logic b, input logic o, input logic c);
    busy = b; oreq = o; creq = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_all(input string req, input logic eo, input logic ec);
    chk(req, operm, eo);
    chk(req, cperm, ec);
    chk(req, ordy, eo);
    chk(req, crdy, ec);
    chk(req, ofire, oreq & eo);
    chk(req, cfire, creq & ec);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    busy = 1'b1; oreq = 1'b1; creq = 1'b1;
    @(negedge clk);
    // R1: reset state, with requests pending
    chk_all("R1", 1'b0, 1'b0);
    do_reset();
    chk_all("R1", 1'b0, 1'b0);

    // Vector table: glitch rejection R3, latency R2, done grant R6, stall R8,
    // accept R9, stickiness R7.
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk_all("R2/R3/R6/R7/R8/R9", VEC[i][1], VEC[i][0]);
    end

    // R10: reset mid-operation clears grants.
    busy = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R10", 1'b0, 1'b0);
    rst_n = 1'b1;

    // R4: timeout boundary, status held high, requests pending (R8 then R9).
    for (int k = 0; k < LIM - 1; k++) step(1'b1, 1'b1, 1'b1);
    chk_all("R4/R8/R10", 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk_all("R4/R9", 1'b1, 1'b0);

    // R5: long wait with status high never grants compound.
    for (int k = 0; k < 2000; k++) step(1'b1, 1'b1, 1'b1);
    chk_all("R5", 1'b1, 1'b0);

    // R2: held low, grant after exactly four edges.
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1);
    chk_all("R2", 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk_all("R2/R9", 1'b1, 1'b1);

    // R7: status back high keeps both grants.
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1);
    chk_all("R7", 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule